// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one data word into a serial asynchronous frame on a single line. A frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, and then one or two high stop bits. The data length, the parity mode and the stop count are set at runtime. All three are captured together with the word when a frame is accepted.

Bit timing comes from outside the block. A one-cycle `tick` pulse marks each bit boundary, and the current bit changes only on a cycle where `tick` is high. While `busy` is high the transmitter owns the line. When no frame is in progress the line rests high. The parity bit is a reduction XOR over the active data bits only, so bits above the chosen length play no part in it.

Top module: `uart_frame_tx`

## Requirements
- R1: One cycle after a `send` is accepted, `txd` is low (the start bit) and `busy` is high. The start bit lasts until the first `tick` after acceptance.
- R2: Out of reset and whenever no frame is in progress, `txd` is high and `busy` is low.
- R3: The data bits follow the start bit, least significant bit first. Their count is 5 + `cfg_len`, so `cfg_len` values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits.
- R4: With `cfg_parity` = 1 (even) or 2 (odd), one parity bit follows the last data bit. In even mode the number of ones over the active data bits plus the parity bit is even. In odd mode that number is odd.
- R5: With `cfg_parity` = 0 or 3 there is no parity slot, and the first stop bit follows the last data bit directly.
- R6: The frame ends with high stop bits: one when `cfg_two_stop` = 0, two when it is 1.
- R7: `busy` stays high from the cycle after acceptance until the `tick` that ends the last stop bit. It is low in the cycle after that tick. A `send` that arrives while `busy` is high is ignored.
- R8: While `busy` is high, `txd` changes only in the cycle that follows a `tick`, and each `tick` advances the frame by exactly one bit.
- R9: The data and all configuration inputs are sampled only on the accepting cycle. Changing them during a frame has no effect on that frame.
- R10: For data 0x29 with 8 data bits and even parity, the parity bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-boundary pulse, one cycle wide |
| send | input | 1 | Start request; accepted only when idle |
| data | input | DATA_W | Word to transmit |
| cfg_len | input | LEN_W | Data length select (5 + value) |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |

## Verification
A fault in the bit counter or the phase register appears on `txd` at the next `tick`: bits are missing, repeated or arrive out of order. It appears on `busy` at the end of the frame, which comes early or late. A bad parity latch or length latch shows up within one frame, at the parity slot. A fault in the capture of configuration at acceptance only shows when the inputs change during a frame. The bench changes them on almost every cycle and compares both outputs on every clock, so such a fault is seen within the frame where it happens.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } phase_e;

  function automatic logic mode_has_parity(input par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              lsb
);

  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= load_data;
    end else if (shift) begin
      sreg <= {1'b0, sreg[DATA_W-1:1]};
    end
  end

  assign lsb = sreg[0];

endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
  import uart_frame_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             tick,
  input  logic [CNT_W-1:0] nbits,
  input  logic             use_par,
  input  logic             two_stop,
  output phase_e           phase,
  output logic             shift_en,
  output logic             frame_done
);

  logic [CNT_W-1:0] sent_cnt;
  logic             extra_stop;
  logic             last_data;

  assign last_data  = (sent_cnt == nbits - CNT_W'(1));
  assign shift_en   = tick && (phase == PH_DATA);
  assign frame_done = tick && (phase == PH_STOP) && !extra_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sent_cnt   <= '0;
      extra_stop <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_START;
            sent_cnt <= '0;
          end
        end
        PH_START: begin
          if (tick) phase <= PH_DATA;
        end
        PH_DATA: begin
          if (tick) begin
            if (last_data) begin
              phase      <= use_par ? PH_PARITY : PH_STOP;
              extra_stop <= two_stop;
            end else begin
              sent_cnt <= sent_cnt + CNT_W'(1);
            end
          end
        end
        PH_PARITY: begin
          if (tick) phase <= PH_STOP;
        end
        PH_STOP: begin
          if (tick) begin
            if (extra_stop) extra_stop <= 1'b0;
            else            phase      <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              send,
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_two_stop,
  output logic              txd,
  output logic              busy
);

  localparam int MIN_BITS = DATA_W - (2 ** LEN_W) + 1;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  function automatic logic [CNT_W-1:0] active_bits(input logic [LEN_W-1:0] sel);
    return CNT_W'(MIN_BITS) + CNT_W'(sel);
  endfunction

  function automatic logic frame_parity(input logic [DATA_W-1:0] d,
                                        input logic [CNT_W-1:0]  n,
                                        input par_mode_e         m);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < n) acc = acc ^ d[i];
    end
    return (m == PAR_ODD) ? ~acc : acc;
  endfunction

  phase_e           phase;
  logic             accept;
  logic             bit_adv;
  logic             frame_done;
  logic             shift_en;
  logic             data_lsb;
  logic [CNT_W-1:0] nbits_q;
  logic             use_par_q;
  logic             two_stop_q;
  logic             par_bit_q;
  logic [CNT_W-1:0] nbits_in;
  par_mode_e        mode_in;

  assign busy     = (phase != PH_IDLE);
  assign accept   = send && !busy;
  assign bit_adv  = tick && busy;
  assign nbits_in = active_bits(cfg_len);
  assign mode_in  = par_mode_e'(cfg_parity);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits_q    <= CNT_W'(DATA_W);
      use_par_q  <= 1'b0;
      two_stop_q <= 1'b0;
      par_bit_q  <= 1'b0;
    end else if (accept) begin
      nbits_q    <= nbits_in;
      use_par_q  <= mode_has_parity(mode_in);
      two_stop_q <= cfg_two_stop;
      par_bit_q  <= frame_parity(data, nbits_in, mode_in);
    end
  end

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (data),
    .shift     (shift_en),
    .lsb       (data_lsb)
  );

  uart_tx_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .tick       (bit_adv),
    .nbits      (nbits_q),
    .use_par    (use_par_q),
    .two_stop   (two_stop_q),
    .phase      (phase),
    .shift_en   (shift_en),
    .frame_done (frame_done)
  );

  always_comb begin
    unique case (phase)
      PH_START:  txd = 1'b0;
      PH_DATA:   txd = data_lsb;
      PH_PARITY: txd = par_bit_q;
      default:   txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic busy,
  input logic txd,
  input logic accept,
  input logic frame_done
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);                                  // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd && busy));                      // R1

  AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> txd);                             // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);                           // R7

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy);                 // R7

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));               // R8

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .busy       (busy),
  .txd        (txd),
  .accept     (accept),
  .frame_done (frame_done)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       send = 1'b0;
  logic [7:0] data = 8'h00;
  logic [1:0] cfg_len = 2'd0;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic       txd;
  logic       busy;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit r10_on = 1'b0;
  bit run_ticks = 1'b0;

  bit    exp_bits[$];
  string exp_tags[$];

  always #2 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .send(send), .data(data),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  // Reference model: a queue holding the remaining line levels of the frame.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_bits.delete();
      exp_tags.delete();
    end else if (exp_bits.size() > 0) begin
      if (tick) begin
        void'(exp_bits.pop_front());
        void'(exp_tags.pop_front());
      end
    end else if (send) begin
      int n;
      int ones;
      n = 5 + int'(cfg_len);
      ones = 0;
      exp_bits.push_back(1'b0); exp_tags.push_back("R1/R8");
      for (int i = 0; i < n; i++) begin
        exp_bits.push_back(data[i]); exp_tags.push_back("R3/R8/R9");
        ones += int'(data[i]);
      end
      if (cfg_parity == 2'd1 || cfg_parity == 2'd2) begin
        // R4: even mode makes total ones even, odd mode makes it odd
        exp_bits.push_back((cfg_parity == 2'd1) ? bit'(ones % 2) : bit'(1 - ones % 2));
        exp_tags.push_back("R4/R9");
        exp_bits.push_back(1'b1); exp_tags.push_back("R6");
      end else begin
        // R5: no parity slot, first stop bit directly after data
        exp_bits.push_back(1'b1); exp_tags.push_back("R5/R6");
      end
      if (cfg_two_stop) begin
        exp_bits.push_back(1'b1); exp_tags.push_back("R6/R9");
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    bit    exp_txd;
    string tg;
    cycles++;
    exp_txd = (exp_bits.size() > 0) ? exp_bits[0] : 1'b1;
    tg      = (exp_bits.size() > 0) ? exp_tags[0] : "R2";
    check(txd === exp_txd, tg, int'(txd), int'(exp_txd));
    check(busy === (exp_bits.size() > 0), "R7/R9", int'(busy), int'(exp_bits.size() > 0));
    if (r10_on && exp_bits.size() > 0 && exp_tags[0] == "R4/R9")
      check(txd === 1'b1, "R10", int'(txd), 1);
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Tick driver
  initial begin
    forever begin
      @(negedge clk);
      tick <= run_ticks && (($urandom % 3) == 0);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    run_ticks = 1'b1;
    // Directed R10 frame: 0x29, 8 bits, even parity, one stop
    r10_on = 1'b1;
    send <= 1'b1; data <= 8'h29; cfg_len <= 2'd3; cfg_parity <= 2'd1; cfg_two_stop <= 1'b0;
    @(negedge clk);
    send <= 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    r10_on = 1'b0;
    // Random traffic: inputs change freely during frames (R9, R7 ignored sends)
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      send         <= (($urandom % 6) == 0);
      data         <= 8'($urandom);
      cfg_len      <= 2'($urandom);
      cfg_parity   <= 2'($urandom);
      cfg_two_stop <= 1'($urandom);
    end
    send <= 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule